// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a 16-bit up-counter that advances on a single-cycle count-enable tick and watches three compare registers (channels A, B and C). When the count equals a channel's compare value, the matching flag rises one tick later. A fourth flag marks the counter passing from its all-ones value back to zero. Software clears flags by writing ones to a flag-clear address, or an interrupt controller clears them by pulsing the per-flag acknowledge input. Each flag is gated by its own enable bit to form an interrupt request.

Two counting modes are selected by a two-bit mode field. In free-running mode the counter wraps from 0xFFFF to 0x0000. In clear-on-compare mode the counter restarts at zero after it reaches the channel A compare value, which makes channel A set the counting period. Force-compare writes are accepted but change neither the flags nor the counter, since no pins are driven from compare events.

Top module: `matchTimer`

## Requirements
- R1: After reset the count, every flag, every interrupt request, the mode field, the three compare values and the enable bits are all zero.
- R2: With a mode code other than 1 the count rises by one on each edge where tick is high, holds when tick is low, and wraps from 0xFFFF to 0x0000.
- R3: With mode code 1 (written to address 0, data bits [1:0]) the count becomes 0 on the tick edge at which it equals the channel A compare value.
- R4: Flag bits 1, 2 and 3 (channels A, B, C) are set at the tick edge that follows the tick edge at which the count equaled that channel's compare value; flags only rise at tick edges.
- R5: Flag bit 0 is set at the tick edge that moves the count from 0xFFFF to 0x0000.
- R6: A write to address 6 clears every flag whose data bit is one; data bits that are zero leave their flags unchanged.
- R7: A high intAck bit clears the flag at the same position (bit 0 wrap, bit 1 A, bit 2 B, bit 3 C) at the next edge.
- R8: When a set event and a clear (write-one or acknowledge) hit the same flag in one cycle, the flag ends up set.
- R9: Writes to address 5 (force-compare, data bits [2:0] for A, B, C) never set a flag and never change the count.
- R10: Flag register bits 4 (reserved), 5 (inert capture position), 6 and 7 always read zero, whatever is written.
- R11: irq[i] is high exactly when flag bit i and enable bit i are both set; the enable bits are data bits [3:0] of a write to address 4.
- R12: Writes to addresses 1, 2 and 3 load the 16-bit compare values of channels A, B and C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable pulse; one count step per high cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| intAck | input | 4 | Per-flag interrupt acknowledge, clears the flag |
| count | output | 16 | Current counter value |
| flags | output | 8 | Flag register (bit 0 wrap, 1..3 compare A..C, 4..7 zero) |
| irq | output | 4 | Per-flag interrupt request, flag AND enable |

## Verification
The assertions assume every input is a known value once reset is released and that a flag can only be set when tick is high, so a cycle with tick low is a safe window to check that a write-one clear or an acknowledge leaves the flag low. The bench keeps to this by driving all inputs at the falling edge from zero, and by issuing clears and acknowledges in cycles without a tick except in the one directed case that checks set-over-clear priority. Compare values are loaded before the first tick so that the matches observed come from known counts rather than from the zero-valued compare registers at reset.

// File: rtl/matchTimerPkg.sv
package matchTimerPkg;

  // number of compare channels; flag vector holds one more for the wrap flag
  localparam int unsigned CHANNELS = 3;
  localparam int unsigned FLAG_USED = CHANNELS + 1;

  // register addresses (behavioural: bench and software decode these)
  localparam int unsigned ADDR_MODE    = 0;
  localparam int unsigned ADDR_CMP0    = 1;  // channels follow at +1, +2
  localparam int unsigned ADDR_IEN     = 4;
  localparam int unsigned ADDR_FORCE   = 5;
  localparam int unsigned ADDR_FLAGCLR = 6;

  localparam logic [1:0] MODE_FREE = 2'd0;
  localparam logic [1:0] MODE_CTC  = 2'd1;

  // strobes from control to datapath
  typedef struct packed {
    logic [1:0]          mode;
    logic [CHANNELS-1:0] cmpLoad;
    logic                tickEn;
  } ctlStrobes_t;

  // events from datapath back to control
  typedef struct packed {
    logic [CHANNELS-1:0] cmpHit;
    logic                wrapHit;
  } pathEvents_t;

endpackage

// File: rtl/matchTimerPath.sv
module matchTimerPath
  import matchTimerPkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [CNT_W-1:0]  loadData,
  output logic [CNT_W-1:0]  count,
  output pathEvents_t       evt
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0]    cmpReg [CHANNELS];
  logic [CNT_W-1:0]    cntReg;
  logic [CHANNELS-1:0] eqNow;
  logic [CHANNELS-1:0] pendHit;
  logic                periodEnd;

  // compare registers and equality detectors, one per channel
  for (genvar ch = 0; ch < CHANNELS; ch++) begin : gChan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpReg[ch] <= '0;
      end else if (ctl.cmpLoad[ch]) begin
        cmpReg[ch] <= loadData;
      end
    end
    assign eqNow[ch] = (cntReg == cmpReg[ch]);
  end

  assign periodEnd = (ctl.mode == MODE_CTC) && eqNow[0];

  // counter: restart after channel A in clear-on-compare mode, else wrap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg <= '0;
    end else if (ctl.tickEn) begin
      if (periodEnd) begin
        cntReg <= '0;
      end else begin
        cntReg <= cntReg + CNT_ONE;
      end
    end
  end

  // a match seen at one tick is reported at the next tick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendHit <= '0;
    end else if (ctl.tickEn) begin
      pendHit <= eqNow;
    end
  end

  assign evt.cmpHit  = pendHit & {CHANNELS{ctl.tickEn}};
  assign evt.wrapHit = ctl.tickEn && (cntReg == CNT_TOP);
  assign count       = cntReg;

endmodule

// File: rtl/matchTimerCtrl.sv
module matchTimerCtrl
  import matchTimerPkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned FLAG_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [FLAG_USED-1:0] wrBits,
  input  logic [FLAG_USED-1:0] intAck,
  input  pathEvents_t          evt,
  output ctlStrobes_t          ctl,
  output logic [FLAG_W-1:0]    flags,
  output logic [FLAG_USED-1:0] irq
);

  localparam int unsigned PAD_W = FLAG_W - FLAG_USED;

  logic [1:0]           modeReg;
  logic [FLAG_USED-1:0] ienReg;
  logic [FLAG_USED-1:0] flagReg;
  logic [FLAG_USED-1:0] clrMask;
  logic [FLAG_USED-1:0] setVec;
  logic                 modeWr;
  logic                 ienWr;
  logic                 clrWr;

  assign modeWr = wrEn && (wrAddr == ADDR_W'(ADDR_MODE));
  assign ienWr  = wrEn && (wrAddr == ADDR_W'(ADDR_IEN));
  assign clrWr  = wrEn && (wrAddr == ADDR_W'(ADDR_FLAGCLR));
  // writes to ADDR_FORCE decode to nothing: no pin and no flag is touched

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : gLoad
    assign ctl.cmpLoad[ch] = wrEn && (wrAddr == ADDR_W'(ADDR_CMP0 + ch));
  end

  assign ctl.mode   = modeReg;
  assign ctl.tickEn = tick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= MODE_FREE;
      ienReg  <= '0;
    end else begin
      if (modeWr) modeReg <= wrBits[1:0];
      if (ienWr)  ienReg  <= wrBits;
    end
  end

  // clears first, then sets, so a same-cycle set event wins
  assign clrMask = (clrWr ? wrBits : '0) | intAck;
  assign setVec  = {evt.cmpHit, evt.wrapHit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagReg <= '0;
    end else begin
      flagReg <= (flagReg & ~clrMask) | setVec;
    end
  end

  assign flags = {{PAD_W{1'b0}}, flagReg};
  assign irq   = flagReg & ienReg;

endmodule

// File: rtl/matchTimer.sv
module matchTimer
  import matchTimerPkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned FLAG_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [CNT_W-1:0]     wrData,
  input  logic [FLAG_USED-1:0] intAck,
  output logic [CNT_W-1:0]     count,
  output logic [FLAG_W-1:0]    flags,
  output logic [FLAG_USED-1:0] irq
);

  ctlStrobes_t ctlToPath;
  pathEvents_t pathToCtl;

  matchTimerCtrl #(
    .ADDR_W (ADDR_W),
    .FLAG_W (FLAG_W)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrBits (wrData[FLAG_USED-1:0]),
    .intAck (intAck),
    .evt    (pathToCtl),
    .ctl    (ctlToPath),
    .flags  (flags),
    .irq    (irq)
  );

  matchTimerPath #(
    .CNT_W (CNT_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctlToPath),
    .loadData (wrData),
    .count    (count),
    .evt      (pathToCtl)
  );

endmodule

// File: rtl/matchTimerChk.sv
module matchTimerChk
  import matchTimerPkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned FLAG_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tick,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    wrAddr,
  input logic [CNT_W-1:0]     wrData,
  input logic [FLAG_USED-1:0] intAck,
  input logic [CNT_W-1:0]     count,
  input logic [FLAG_W-1:0]    flags,
  input logic [FLAG_USED-1:0] irq
);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq & ~flags[FLAG_USED-1:0]) == '0);

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(count));

  // R4
  flag_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(flags[FLAG_USED-1:0] & ~$past(flags[FLAG_USED-1:0]))) |-> $past(tick));

  // R5
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && count == {CNT_W{1'b1}}) |=> (count == '0 && flags[0]));

  for (genvar b = 0; b < FLAG_USED; b++) begin : gFlag
    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (intAck[b] && !tick) |=> !flags[b]);
    // R6
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == ADDR_W'(ADDR_FLAGCLR) && wrData[b] && !tick) |=> !flags[b]);
  end

endmodule

bind matchTimer matchTimerChk #(
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W),
  .FLAG_W (FLAG_W)
) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .tick   (tick),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .wrData (wrData),
  .intAck (intAck),
  .count  (count),
  .flags  (flags),
  .irq    (irq)
);

// File: tb/sim_matchTimer.sv
`timescale 1ns/1ps
module sim_matchTimer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  intAck = '0;
  logic [15:0] count;
  logic [7:0]  flags;
  logic [3:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  matchTimer u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .intAck(intAck), .count(count), .flags(flags), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [15:0] data;
    logic        tk;
    logic [3:0]  ack;
    logic [15:0] expCount;
    logic [7:0]  expFlags;
    logic [3:0]  expIrq;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd1, 16'd3,  1'b0, 4'h0, 16'd0,  8'h00, 4'h0}, // R12 cmpA=3
    '{1'b1, 3'd2, 16'd5,  1'b0, 4'h0, 16'd0,  8'h00, 4'h0}, // R12 cmpB=5
    '{1'b1, 3'd3, 16'd5,  1'b0, 4'h0, 16'd0,  8'h00, 4'h0}, // R12 cmpC=5
    '{1'b1, 3'd4, 16'hF,  1'b0, 4'h0, 16'd0,  8'h00, 4'h0}, // R11 enables
    '{1'b0, 3'd0, 16'd0,  1'b1, 4'h0, 16'd1,  8'h00, 4'h0}, // R2
    '{1'b0, 3'd0, 16'd0,  1'b1, 4'h0, 16'd2,  8'h00, 4'h0},
    '{1'b0, 3'd0, 16'd0,  1'b1, 4'h0, 16'd3,  8'h00, 4'h0},
    '{1'b0, 3'd0, 16'd0,  1'b1, 4'h0, 16'd4,  8'h00, 4'h0}, // R4 A matched, not yet flagged
    '{1'b0, 3'd0, 16'd0,  1'b1, 4'h0, 16'd5,  8'h02, 4'h2}, // R4 A flag one tick later
    '{1'b0, 3'd0, 16'd0,  1'b1, 4'h0, 16'd6,  8'h02, 4'h2},
    '{1'b0, 3'd0, 16'd0,  1'b1, 4'h0, 16'd7,  8'h0E, 4'hE}, // R4 B and C
    '{1'b1, 3'd6, 16'h0A, 1'b0, 4'h0, 16'd7,  8'h04, 4'h4}, // R6 clear A,C
    '{1'b0, 3'd0, 16'd0,  1'b0, 4'h4, 16'd7,  8'h00, 4'h0}, // R7 ack B
    '{1'b1, 3'd5, 16'd7,  1'b0, 4'h0, 16'd7,  8'h00, 4'h0}, // R9 force
    '{1'b1, 3'd5, 16'd7,  1'b1, 4'h0, 16'd8,  8'h00, 4'h0}, // R9 force with tick
    '{1'b1, 3'd1, 16'd10, 1'b0, 4'h0, 16'd8,  8'h00, 4'h0}, // R12 cmpA=10
    '{1'b1, 3'd0, 16'd1,  1'b0, 4'h0, 16'd8,  8'h00, 4'h0}, // R3 mode 1
    '{1'b0, 3'd0, 16'd0,  1'b1, 4'h0, 16'd9,  8'h00, 4'h0},
    '{1'b0, 3'd0, 16'd0,  1'b1, 4'h0, 16'd10, 8'h00, 4'h0},
    '{1'b0, 3'd0, 16'd0,  1'b1, 4'h0, 16'd0,  8'h00, 4'h0}, // R3 restart
    '{1'b0, 3'd0, 16'd0,  1'b1, 4'h0, 16'd1,  8'h02, 4'h2}  // R4 A in mode 1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at falling edge, let one rising edge pass, return at next falling edge
  task automatic step(input logic w, input logic [2:0] a, input logic [15:0] d,
                      input logic t, input logic [3:0] k);
    wrEn = w; wrAddr = a; wrData = d; tick = t; intAck = k;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0; tick = 1'b0; intAck = '0;
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 count", 32'(count), 32'h0);
    check("R1 flags", 32'(flags), 32'h0);
    check("R1 irq",   32'(irq),   32'h0);

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].tk, VECS[i].ack);
      check($sformatf("vector %0d count R2/R3", i), 32'(count), 32'(VECS[i].expCount));
      check($sformatf("vector %0d flags R4/R6/R7/R9", i), 32'(flags), 32'(VECS[i].expFlags));
      check($sformatf("vector %0d irq R11", i), 32'(irq), 32'(VECS[i].expIrq));
    end

    // state now: count 1, mode 1, cmpA 10, flags 0x02, enables 0xF
    step(1'b1, 3'd1, 16'd2, 1'b0, 4'h0);     // cmpA = 2
    step(1'b1, 3'd6, 16'hFF, 1'b0, 4'h0);    // clear all, upper bits inert
    check("R10 upper flag bits", 32'(flags[7:4]), 32'h0);
    check("R6 clear all", 32'(flags), 32'h0);
    step(1'b0, 3'd0, 16'd0, 1'b1, 4'h0);     // 1 -> 2
    step(1'b0, 3'd0, 16'd0, 1'b1, 4'h0);     // 2 -> 0, A match pending
    check("R3 restart at cmpA=2", 32'(count), 32'h0);
    // R8 set wins over write-one clear and acknowledge in the same cycle
    step(1'b1, 3'd6, 16'h0002, 1'b1, 4'h2);
    check("R8 set beats clear", 32'(flags), 32'h02);
    check("R8 count", 32'(count), 32'h1);

    step(1'b1, 3'd4, 16'h0, 1'b0, 4'h0);     // R11 disable all
    check("R11 irq gated off", 32'(irq), 32'h0);
    check("R11 flag kept", 32'(flags), 32'h02);

    step(1'b1, 3'd0, 16'd2, 1'b0, 4'h0);     // mode code 2 acts as free-running
    step(1'b0, 3'd0, 16'd0, 1'b1, 4'h0);     // 1 -> 2
    step(1'b0, 3'd0, 16'd0, 1'b1, 4'h0);     // 2 -> 3, no restart
    check("R2 mode 2 free-running", 32'(count), 32'h3);
    step(1'b1, 3'd6, 16'h0, 1'b0, 4'h0);     // write zeros
    check("R6 zero write keeps flags", 32'(flags), 32'h02);

    step(1'b1, 3'd6, 16'h1, 1'b0, 4'h0);     // clear wrap flag
    while (count != 16'hFFFF) step(1'b0, 3'd0, 16'd0, 1'b1, 4'h0);
    check("R5 no wrap flag before wrap", 32'(flags[0]), 32'h0);
    step(1'b0, 3'd0, 16'd0, 1'b1, 4'h0);
    check("R5 count wrapped", 32'(count), 32'h0);
    check("R5 wrap flag set", 32'(flags[0]), 32'h1);
    check("R10 upper bits after run", 32'(flags[7:4]), 32'h0);

    finish();
  end

endmodule